// File: doc/BRIEF.md
# Programmable Interval Down-Counter

This block is a down-counting timer placed behind a small word-addressed register interface. Software programs a reload value, picks a counter width (16 or 32 bits), a prescale ratio, and a wrap behaviour. It then sets the run bit. Each time the prescaled tick takes the counter through zero, an expiry is recorded in a raw interrupt flag. A level interrupt output reports that flag whenever interrupts are enabled.

Two ways of writing the reload value are offered. The immediate form restarts the count at once. The background form leaves the running count alone and only changes the value taken at the next reload. Wrapping can be periodic, which returns to the reload value, or free-running, which returns to all-ones of the selected width. A one-shot option parks the counter at zero after its first expiry. It stays there until software writes the immediate reload register again. Writes and reads are single-cycle strobes: a write takes effect at the clock edge, and read data is combinational from the address.

Top module: `ivt_timer`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable set, run clear), and the count, the reload value and both status registers read zero. The interrupt output is low.
- R2: Word offsets select registers: 0 reload (immediate), 1 current count, 2 control (bits 7:0, upper bits read zero), 3 interrupt clear (reads zero), 4 raw status, 5 masked status, 6 reload (background), 7 unused (reads zero). Both reload offsets read back the stored reload value.
- R3: A write to offset 0 stores the value and sets the count to it at the same clock edge. A write to offset 1 changes nothing.
- R4: A write to offset 6 stores the reload value without changing the current count. The new value is used at the next reload.
- R5: While control bit 7 (run) is set, each prescaled tick decrements a nonzero count by one. A tick that arrives while the count is zero is an expiry, so one period lasts reload+1 ticks.
- R6: When control bit 6 is 1 (periodic), an expiry loads the count from the stored reload value. When it is 0 (free-running), an expiry wraps the count to all-ones of the selected width.
- R7: Control bit 1 selects 32-bit counting when 1. When it is 0, only the low 16 bits count, and the count's upper 16 bits read as zero.
- R8: When control bit 0 (one-shot) is set, the counter holds at zero after an expiry and ignores further ticks until offset 0 is written.
- R9: Control bits 3:2 select the prescaler: 00 gives one count tick per enabled input tick, 01 one per 16, 10 one per 256, and 11 acts as 00. Input ticks advance the prescaler only while the run bit is set.
- R10: A write to the control register or to offset 0 restarts the prescaler phase from zero.
- R11: An expiry sets the raw flag (bit 0 of offset 4). Any write to offset 3 clears it. If both happen in the same cycle, the expiry wins.
- R12: The interrupt output and bit 0 of offset 5 both equal the raw flag ANDed with control bit 5. All upper status bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Input tick qualifier feeding the prescaler |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_out | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is a prescaler that is part-way through a divide-by-16 cycle when the control register is rewritten. Only then can a missing phase restart be told apart from a correct one. The stimulus runs eight enabled ticks, rewrites the same control value, and then shows that fifteen further ticks leave the count unchanged and the sixteenth decrements it. Divide-by-256 boundaries, the one-shot hold that follows an expiry, and the 16-bit free-running wrap are each driven by exact tick counts worked out from the reload value.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  localparam int unsigned CTRL_W     = 8;
  localparam int unsigned ADDR_W     = 3;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

  typedef enum logic [ADDR_W-1:0] {
    OFF_RELOAD  = 3'd0,
    OFF_COUNT   = 3'd1,
    OFF_CTRL    = 3'd2,
    OFF_CLEAR   = 3'd3,
    OFF_RAW     = 3'd4,
    OFF_MASKED  = 3'd5,
    OFF_BGLOAD  = 3'd6,
    OFF_SPARE   = 3'd7
  } reg_off_e;

  typedef enum logic [1:0] {
    PRE_DIV1   = 2'b00,
    PRE_DIV16  = 2'b01,
    PRE_DIV256 = 2'b10,
    PRE_RSVD   = 2'b11
  } pre_sel_e;

  // Control layout, msb first; bit positions are visible to software.
  typedef struct packed {
    logic     run;       // 7
    logic     periodic;  // 6
    logic     irq_en;    // 5
    logic     spare;     // 4
    pre_sel_e pre;       // 3:2
    logic     wide;      // 1
    logic     oneshot;   // 0
  } ctrl_t;

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler
  import ivt_pkg::*;
#(
  parameter int unsigned PRE_W    = 8,
  parameter int unsigned PRE_LO_W = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     tick_en,
  input  pre_sel_e sel,
  input  logic     restart,
  output logic     cnt_tick
);

  logic [PRE_W-1:0] phase;
  logic             advance;

  function automatic logic phase_hit(pre_sel_e s, logic [PRE_W-1:0] p);
    case (s)
      PRE_DIV16:  return &p[PRE_LO_W-1:0];
      PRE_DIV256: return &p;
      default:    return 1'b1;
    endcase
  endfunction

  assign advance  = run && tick_en;
  assign cnt_tick = advance && phase_hit(sel, phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (advance) phase <= phase + 1'b1;
  end

  // R9: with no enabled input tick the phase must not move
  a_r9_idle_holds_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !restart) |=> $stable(phase));

  // R10: a restart request leaves the phase at zero
  a_r10_restart_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase == '0));

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic              wide,
  input  logic              periodic,
  input  logic              oneshot,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] load_data,
  input  logic [DATA_W-1:0] reload_val,
  output logic [DATA_W-1:0] count_q,
  output logic              expire
);

  logic [DATA_W-1:0] cnt_r;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] cur;
  logic              halted;
  logic              step;

  function automatic logic [DATA_W-1:0] width_mask(logic w);
    return w ? {DATA_W{1'b1}} : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  endfunction

  function automatic logic [DATA_W-1:0] wrap_value(logic per, logic [DATA_W-1:0] rl,
                                                   logic [DATA_W-1:0] m);
    return per ? (rl & m) : m;
  endfunction

  assign mask    = width_mask(wide);
  assign cur     = cnt_r & mask;
  assign count_q = cur;
  assign step    = cnt_tick && !halted && !load_wr;
  assign expire  = step && (cur == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r  <= '0;
      halted <= 1'b0;
    end else if (load_wr) begin
      cnt_r  <= load_data & mask;
      halted <= 1'b0;
    end else if (step) begin
      if (cur != '0) begin
        cnt_r <= cur - 1'b1;
      end else if (oneshot) begin
        cnt_r  <= '0;
        halted <= 1'b1;
      end else begin
        cnt_r <= wrap_value(periodic, reload_val, mask);
      end
    end
  end

  // R3: an immediate reload write shows at the count next cycle
  a_r3_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (count_q == ($past(load_data & mask) & mask)));

  // R5: a tick on a nonzero count steps it down by one
  a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cur != '0) |=> (count_q == (($past(cur) - 1'b1) & mask)));

  // R8: a parked one-shot counter stays at zero until reloaded
  a_r8_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !load_wr) |=> (count_q == '0));

endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              expire,
  input  logic [DATA_W-1:0] count_val,
  output ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] reload_q,
  output logic              load_wr,
  output logic              ctrl_wr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);

  logic raw_q;
  logic clr_wr;
  logic bg_wr;
  logic masked;

  assign load_wr = reg_wr && (reg_off_e'(reg_addr) == OFF_RELOAD);
  assign ctrl_wr = reg_wr && (reg_off_e'(reg_addr) == OFF_CTRL);
  assign clr_wr  = reg_wr && (reg_off_e'(reg_addr) == OFF_CLEAR);
  assign bg_wr   = reg_wr && (reg_off_e'(reg_addr) == OFF_BGLOAD);
  assign masked  = raw_q && ctrl_q.irq_en;
  assign irq_out = masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= ctrl_t'(CTRL_RESET);
      reload_q <= '0;
      raw_q    <= 1'b0;
    end else begin
      if (ctrl_wr)             ctrl_q   <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (load_wr || bg_wr)    reload_q <= reg_wdata;
      if (expire)              raw_q    <= 1'b1;
      else if (clr_wr)         raw_q    <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_off_e'(reg_addr))
      OFF_RELOAD, OFF_BGLOAD: reg_rdata = reload_q;
      OFF_COUNT:              reg_rdata = count_val;
      OFF_CTRL:               reg_rdata[CTRL_W-1:0] = ctrl_q;
      OFF_RAW:                reg_rdata[0] = raw_q;
      OFF_MASKED:             reg_rdata[0] = masked;
      default:                reg_rdata = '0;
    endcase
  end

  // R11: an expiry is always recorded in the raw flag
  a_r11_expiry_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw_q);

  // R11: a clear without a competing expiry drops the flag
  a_r11_clear_drops_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire) |=> !raw_q);

  // R4: a background write leaves the control register untouched
  a_r4_bg_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_wr) |=> $stable(ctrl_q));

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned PRE_W    = 8,
  parameter int unsigned PRE_LO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_out
);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] reload;
  logic [DATA_W-1:0] count;
  logic              load_wr;
  logic              ctrl_wr;
  logic              cnt_tick;
  logic              expire;

  ivt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .expire    (expire),
    .count_val (count),
    .ctrl_q    (ctrl),
    .reload_q  (reload),
    .load_wr   (load_wr),
    .ctrl_wr   (ctrl_wr),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  ivt_prescaler #(.PRE_W(PRE_W), .PRE_LO_W(PRE_LO_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl.run),
    .tick_en  (tick_en),
    .sel      (ctrl.pre),
    .restart  (ctrl_wr || load_wr),
    .cnt_tick (cnt_tick)
  );

  ivt_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_tick   (cnt_tick),
    .wide       (ctrl.wide),
    .periodic   (ctrl.periodic),
    .oneshot    (ctrl.oneshot),
    .load_wr    (load_wr),
    .load_data  (reg_wdata),
    .reload_val (reload),
    .count_q    (count),
    .expire     (expire)
  );

  // R12: interrupt output never rises without interrupt enable
  a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.irq_en |-> !irq_out);

endmodule

// File: tb/ivt_timer_tb.sv
module ivt_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  ivt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  // {is_write, offset, wdata, expected read, requirement number}
  localparam int NV = 11;
  localparam logic [75:0] VEC [NV] = '{
    {1'b0, 3'd2, 32'd0,     32'h20, 8'd1},  // R1 control reset value
    {1'b0, 3'd1, 32'd0,     32'h0,  8'd1},  // R1 count zero
    {1'b0, 3'd4, 32'd0,     32'h0,  8'd1},  // R1 raw zero
    {1'b0, 3'd0, 32'd0,     32'h0,  8'd1},  // R1 reload zero
    {1'b1, 3'd0, 32'd5,     32'h0,  8'd3},  // R3 immediate reload write
    {1'b0, 3'd1, 32'd0,     32'd5,  8'd3},  // R3 count follows at once
    {1'b0, 3'd6, 32'd0,     32'd5,  8'd2},  // R2 background offset reads reload
    {1'b1, 3'd1, 32'h99,    32'h0,  8'd3},  // R3 count offset write
    {1'b0, 3'd1, 32'd0,     32'd5,  8'd3},  // R3 ignored
    {1'b0, 3'd7, 32'd0,     32'h0,  8'd2},  // R2 spare offset
    {1'b0, 3'd3, 32'd0,     32'h0,  8'd2}   // R2 clear offset reads zero
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(string req, logic [2:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq low", {31'd0, irq_out}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [75:0] v;
      v = VEC[i];
      if (v[75]) wr(v[74:72], v[71:40]);
      else rd($sformatf("R%0d table %0d", v[7:0], i), v[74:72], v[39:8]);
    end

    // periodic, 32-bit, irq enabled, running, divide by 1
    wr(3'd2, 32'hE2);
    ticks(5);
    rd("R5 five ticks reach zero", 3'd1, 32'd0);
    rd("R11 no flag before expiry", 3'd4, 32'd0);
    ticks(1);
    rd("R6 periodic reload", 3'd1, 32'd5);
    rd("R11 raw after expiry", 3'd4, 32'd1);
    rd("R12 masked with enable", 3'd5, 32'd1);
    check("R12 irq high", {31'd0, irq_out}, 32'd1);

    wr(3'd6, 32'd3);
    rd("R4 background keeps count", 3'd1, 32'd5);
    ticks(6);
    rd("R4 next reload uses background value", 3'd1, 32'd3);
    wr(3'd3, 32'd0);
    rd("R11 clear", 3'd4, 32'd0);
    check("R12 irq low after clear", {31'd0, irq_out}, 32'd0);

    wr(3'd2, 32'hC2);
    ticks(4);
    rd("R11 raw set with irq disabled", 3'd4, 32'd1);
    rd("R12 masked zero when disabled", 3'd5, 32'd0);
    check("R12 irq low when disabled", {31'd0, irq_out}, 32'd0);

    // free-running 16-bit
    wr(3'd2, 32'hA0);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd2);
    ticks(3);
    rd("R6 free wrap 16-bit", 3'd1, 32'h0000FFFF);
    wr(3'd2, 32'hA2);
    wr(3'd0, 32'd0);
    ticks(1);
    rd("R6 free wrap 32-bit", 3'd1, 32'hFFFFFFFF);

    wr(3'd2, 32'h20);
    wr(3'd0, 32'h00012345);
    rd("R7 16-bit count upper zero", 3'd1, 32'h00002345);
    rd("R7 reload keeps full value", 3'd0, 32'h00012345);
    rd("R2 control readback", 3'd2, 32'h20);

    // one-shot
    wr(3'd2, 32'hE3);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd2);
    ticks(3);
    rd("R8 one-shot expiry flag", 3'd4, 32'd1);
    rd("R8 one-shot at zero", 3'd1, 32'd0);
    ticks(5);
    rd("R8 one-shot holds zero", 3'd1, 32'd0);
    wr(3'd0, 32'd4);
    ticks(1);
    rd("R8 reload rearms", 3'd1, 32'd3);

    // prescaler divide by 16
    wr(3'd2, 32'hE6);
    wr(3'd0, 32'd10);
    ticks(15);
    rd("R9 div16 holds for 15", 3'd1, 32'd10);
    ticks(1);
    rd("R9 div16 step on 16th", 3'd1, 32'd9);

    // divide by 256
    wr(3'd2, 32'hEA);
    wr(3'd0, 32'd10);
    ticks(255);
    rd("R9 div256 holds for 255", 3'd1, 32'd10);
    ticks(1);
    rd("R9 div256 step on 256th", 3'd1, 32'd9);

    // code 11 acts as divide by 1
    wr(3'd2, 32'hEE);
    wr(3'd0, 32'd5);
    ticks(2);
    rd("R9 code 11 divides by 1", 3'd1, 32'd3);

    // phase restart on control write
    wr(3'd2, 32'hE6);
    wr(3'd0, 32'd10);
    ticks(8);
    wr(3'd2, 32'hE6);
    ticks(15);
    rd("R10 phase restarted", 3'd1, 32'd10);
    ticks(1);
    rd("R10 step after full restart", 3'd1, 32'd9);

    // run clear blocks counting
    wr(3'd2, 32'h62);
    wr(3'd0, 32'd7);
    ticks(20);
    rd("R9 stopped timer ignores ticks", 3'd1, 32'd7);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule